// File: doc/BRIEF.md
# Down-Counting Interval Timer with Watchdog Bite

This block is a register-programmed interval timer that counts down once per tick enable, normally a 1 MHz strobe made elsewhere from the oscillator. Software writes a reload value, a periodic/one-shot choice and an enable into one register. It reads the live count from a second register, and it acknowledges interrupts through that second register.

When the count passes zero the block raises a level interrupt. In periodic mode it then reloads and runs again; in one-shot mode it stops and drops its own enable. Acknowledging the interrupt takes two steps: software writes a one to the clear bit, then reads the trigger register. The watchdog bite, a sticky reset request, happens when a new expiry arrives while the previous interrupt is still pending. One missed interrupt is therefore tolerated, and the second one causes the reset. The bus is a single-cycle synchronous read/write port, and read data is registered one cycle after the read strobe.

Top module: `dntimer_wdog`

## Requirements
- R1: After reset, `irq` and `rst_req` are 0 and both registers read as 0.
- R2: Address 0 (trigger) holds bit 31 = enable, bit 30 = periodic, bits 28:0 = reload value; it reads back as written, with bit 29 reading 0.
- R3: Writing address 0 with bit 31 set loads the counter from the new reload value on the next tick; address 1 reads the count in bits 28:0 and 0 in bits 31:29.
- R4: The count decreases by one only on a tick, and it holds between ticks. Expiry happens on the tick after the count reaches 0, so the period is reload+1 ticks.
- R5: In periodic mode (bit 30 = 1) the expiry tick reloads the count from the reload value.
- R6: In one-shot mode (bit 30 = 0) the expiry tick clears the enable bit, and the count stays at 0 with no further expiries.
- R7: An expiry sets `irq` on the following clock, and `irq` stays high until it is acknowledged.
- R8: The acknowledge is a write to address 1 with bit 30 set, followed by a read of address 0. A read without the prior write, or a write without the later read, leaves `irq` high.
- R9: An expiry while `irq` is still high sets `rst_req`, which stays high until reset. An expiry with `irq` low, including one after an acknowledge, does not set it.
- R10: Writing 0 to the trigger register stops the count at its present value. After that, no expiry, interrupt or reset request occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Count enable strobe (1 MHz rate) |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 1 | Register select: 0 trigger, 1 count/clear |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the clock after `bus_rd` |
| irq | output | 1 | Expiry interrupt level |
| rst_req | output | 1 | Sticky watchdog reset request |

## Verification
A wrong count or a wrong pending-load state shows up as an `irq` edge one or more ticks away from reload+1. It also shows up as a wrong value on the next count read, at most one period after the fault. An acknowledge state machine that arms or completes at the wrong time either leaves `irq` stuck high or drops it early, and this is visible on the clock after the bus access. A wrong record of a missed expiry shows up as `rst_req` rising at the first unacknowledged expiry or failing to rise at the second. The bench therefore samples `irq` and `rst_req` after every single tick rather than only at the end of a period.

// File: rtl/dnt_pkg.sv
package dnt_pkg;
    localparam int BUS_W   = 32;
    localparam int EN_BIT  = 31;
    localparam int PER_BIT = 30;
    localparam int CLR_BIT = 30;

    typedef enum logic {
        REG_TRIG = 1'b0,
        REG_CNT  = 1'b1
    } reg_sel_e;
endpackage

// File: rtl/dnt_counter.sv
module dnt_counter #(
    parameter int CNT_W = 29
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             run,
    input  logic             periodic,
    input  logic             start,
    input  logic [CNT_W-1:0] reload,
    output logic [CNT_W-1:0] count,
    output logic             expire
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             pend;
    } cnt_st_t;

    cnt_st_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        expire = tick && run && !st_q.pend && (st_q.cnt == '0);
        if (tick && run) begin
            if (st_q.pend) begin
                st_d.cnt  = reload;
                st_d.pend = 1'b0;
            end else if (st_q.cnt == '0) begin
                if (periodic) st_d.cnt = reload;
            end else begin
                st_d.cnt = st_q.cnt - 1'b1;
            end
        end
        if (start) st_d.pend = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign count = st_q.cnt;
endmodule

// File: rtl/dnt_irq.sv
module dnt_irq #(
    parameter bit WDOG_EN = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic expire,
    input  logic clr_wr,
    input  logic trig_rd,
    output logic irq,
    output logic rst_req
);
    typedef struct packed {
        logic irq;
        logic arm;
        logic bite;
    } irq_st_t;

    irq_st_t st_d, st_q;
    logic    ack;

    always_comb begin
        st_d = st_q;
        ack  = st_q.arm && trig_rd;
        if (clr_wr)   st_d.arm = 1'b1;
        else if (ack) st_d.arm = 1'b0;
        if (expire)   st_d.irq = 1'b1;
        else if (ack) st_d.irq = 1'b0;
        if (WDOG_EN && expire && st_q.irq && !ack) st_d.bite = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign irq     = st_q.irq;
    assign rst_req = st_q.bite;
endmodule

// File: rtl/dntimer_wdog.sv
module dntimer_wdog #(
    parameter int CNT_W   = 29,
    parameter bit WDOG_EN = 1'b1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     tick,
    input  logic                     bus_wr,
    input  logic                     bus_rd,
    input  logic                     bus_addr,
    input  logic [dnt_pkg::BUS_W-1:0] bus_wdata,
    output logic [dnt_pkg::BUS_W-1:0] bus_rdata,
    output logic                     irq,
    output logic                     rst_req
);
    import dnt_pkg::*;

    localparam int PAD_W = BUS_W - CNT_W;

    typedef struct packed {
        logic             en;
        logic             per;
        logic [CNT_W-1:0] reload;
        logic [BUS_W-1:0] rdata;
    } top_st_t;

    top_st_t          st_d, st_q;
    logic             trig_wr, cnt_wr, trig_rd, start, clr_wr, expire;
    logic [CNT_W-1:0] count;

    always_comb begin
        trig_wr = bus_wr && (bus_addr == REG_TRIG);
        cnt_wr  = bus_wr && (bus_addr == REG_CNT);
        trig_rd = bus_rd && (bus_addr == REG_TRIG);
        start   = trig_wr && bus_wdata[EN_BIT];
        clr_wr  = cnt_wr && bus_wdata[CLR_BIT];
        st_d    = st_q;
        if (expire && !st_q.per) st_d.en = 1'b0;
        if (trig_wr) begin
            st_d.en     = bus_wdata[EN_BIT];
            st_d.per    = bus_wdata[PER_BIT];
            st_d.reload = bus_wdata[CNT_W-1:0];
        end
        if (bus_rd) begin
            if (bus_addr == REG_TRIG)
                st_d.rdata = {st_q.en, st_q.per, {(PAD_W-2){1'b0}}, st_q.reload};
            else
                st_d.rdata = {{PAD_W{1'b0}}, count};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    dnt_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .run      (st_q.en),
        .periodic (st_q.per),
        .start    (start),
        .reload   (st_q.reload),
        .count    (count),
        .expire   (expire)
    );

    dnt_irq #(.WDOG_EN(WDOG_EN)) u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .expire  (expire),
        .clr_wr  (clr_wr),
        .trig_rd (trig_rd),
        .irq     (irq),
        .rst_req (rst_req)
    );

    assign bus_rdata = st_q.rdata;
endmodule

// File: rtl/dntimer_wdog_chk.sv
module dntimer_wdog_chk #(
    parameter int CNT_W = 29
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick,
    input logic             bus_wr,
    input logic             bus_rd,
    input logic             bus_addr,
    input logic             irq,
    input logic             rst_req,
    input logic             expire,
    input logic             en,
    input logic             per,
    input logic [CNT_W-1:0] count,
    input logic [CNT_W-1:0] reload
);
    logic trig_wr, trig_rd;
    assign trig_wr = bus_wr && !bus_addr;
    assign trig_rd = bus_rd && !bus_addr;

    a_r4_count_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(count));

    a_r5_periodic_reload: assert property (@(posedge clk) disable iff (!rst_n)
        expire && per && !trig_wr |=> count == reload);

    a_r6_oneshot_stop: assert property (@(posedge clk) disable iff (!rst_n)
        expire && !per && !trig_wr |=> !en);

    a_r7_irq_on_expire: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> irq);

    a_r8_irq_needs_read: assert property (@(posedge clk) disable iff (!rst_n)
        irq && !trig_rd |=> irq);

    a_r9_bite_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_req) |-> $past(irq));

    a_r9_bite_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> rst_req);
endmodule

bind dntimer_wdog dntimer_wdog_chk #(.CNT_W(CNT_W)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .bus_wr   (bus_wr),
    .bus_rd   (bus_rd),
    .bus_addr (bus_addr),
    .irq      (irq),
    .rst_req  (rst_req),
    .expire   (expire),
    .en       (st_q.en),
    .per      (st_q.per),
    .count    (count),
    .reload   (st_q.reload)
);

// File: tb/dntimer_wdog_tb.sv
module dntimer_wdog_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic        bus_addr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq, rst_req;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [31:0] rv;

    always #4 clk = ~clk;

    dntimer_wdog dut_i (
        .clk(clk), .rst_n(rst_n), .tick(tick), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq), .rst_req(rst_req)
    );

    function automatic logic [31:0] trig_val(bit en, bit per, int n);
        return {en, per, 1'b0, 29'(n)};
    endfunction

    function automatic logic [31:0] cnt_after_expiry(bit per, int n);
        return per ? 32'(n) : 32'd0;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic bus_write(logic a, logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic bus_read(logic a, output logic [31:0] d);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic do_tick();
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic ack();
        logic [31:0] t;
        bus_write(1'b1, 32'h4000_0000);
        bus_read(1'b0, t);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h00C0FFEE));
        do_reset();
        // R1 reset state
        check("R1 irq", 32'(irq), 0);
        check("R1 rst_req", 32'(rst_req), 0);
        bus_read(1'b0, rv); check("R1 trig", rv, 0);
        bus_read(1'b1, rv); check("R1 count", rv, 0);

        // R2 / R3 / R4 / R5 / R7 directed periodic run
        bus_write(1'b0, trig_val(1, 1, 5));
        bus_read(1'b0, rv); check("R2 trig readback", rv, trig_val(1, 1, 5));
        do_tick();
        bus_read(1'b1, rv); check("R3 loaded count", rv, 5);
        for (int k = 0; k < 5; k++) begin
            do_tick();
            check("R4 no early irq", 32'(irq), 0);
        end
        bus_read(1'b1, rv); check("R4 count at zero", rv, 0);
        repeat (6) @(negedge clk);
        bus_read(1'b1, rv); check("R4 holds without tick", rv, 0);
        do_tick();
        check("R7 irq at period", 32'(irq), 1);
        bus_read(1'b1, rv); check("R5 reloaded", rv, cnt_after_expiry(1, 5));

        // R8 acknowledge sequencing
        bus_read(1'b0, rv);
        check("R8 read alone keeps irq", 32'(irq), 1);
        bus_write(1'b1, 32'h4000_0000);
        check("R8 write alone keeps irq", 32'(irq), 1);
        bus_read(1'b0, rv);
        check("R8 write+read clears irq", 32'(irq), 0);

        // R9 watchdog: tolerate one miss, bite on the second
        repeat (6) do_tick();
        check("R9 irq", 32'(irq), 1);
        ack();
        repeat (6) do_tick();
        check("R9 acked then expiry no bite", 32'(rst_req), 0);
        repeat (5) do_tick();
        check("R9 no bite before second expiry", 32'(rst_req), 0);
        do_tick();
        check("R9 bite on second miss", 32'(rst_req), 1);
        repeat (3) do_tick();
        check("R9 bite sticky", 32'(rst_req), 1);
        do_reset();
        check("R1 rst_req after reset", 32'(rst_req), 0);

        // R6 one-shot
        bus_write(1'b0, trig_val(1, 0, 3));
        repeat (4) do_tick();
        check("R6 no early irq", 32'(irq), 0);
        do_tick();
        check("R6 irq", 32'(irq), 1);
        bus_read(1'b0, rv); check("R6 enable self-cleared", rv, trig_val(0, 0, 3));
        repeat (10) do_tick();
        bus_read(1'b1, rv); check("R6 count stays 0", rv, 0);
        check("R6 no further expiry", 32'(rst_req), 0);
        ack();

        // R10 stop
        bus_write(1'b0, trig_val(1, 1, 10));
        repeat (4) do_tick();
        bus_write(1'b0, 32'h0);
        bus_write(1'b1, 32'h0);
        repeat (30) do_tick();
        bus_read(1'b1, rv); check("R10 count frozen", rv, 7);
        check("R10 no irq", 32'(irq), 0);
        check("R10 no bite", 32'(rst_req), 0);

        // random periods and modes (R3 R4 R5 R6 R7 R8)
        for (int it = 0; it < 24; it++) begin
            int  n   = int'($urandom_range(0, 12));
            bit  per = 1'($urandom_range(0, 1));
            bus_write(1'b0, trig_val(1, per, n));
            repeat ($urandom_range(0, 3)) @(negedge clk);
            do_tick();
            for (int k = 0; k < n; k++) begin
                do_tick();
                check("R4 rand no early irq", 32'(irq), 0);
            end
            do_tick();
            check("R7 rand irq", 32'(irq), 1);
            bus_read(1'b1, rv); check("R5 R6 rand count", rv, cnt_after_expiry(per, n));
            bus_read(1'b0, rv); check("R6 rand enable", rv, trig_val(per, per, n));
            ack();
            check("R8 rand ack", 32'(irq), 0);
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule